// File: doc/BRIEF.md
# Triple Frame Buffer Controller

This block decides which of three frame slots in external memory a video writer fills and which slot a video reader drains. The writer runs in the capture clock domain and reports the start and end of every frame. The reader runs in its own, unrelated clock domain and reports the start of every frame it fetches. The block answers each side with a slot index and the matching base address. The burst engines on either side then use that address. Because the reader never holds the slot being written, the image it fetches is always a whole frame.

All slot decisions are made in one place, the writer clock domain, so no decision compares indices that came from different clocks. A reader frame start crosses into the writer domain as a toggle pulse. The slot that the arbiter grants to the reader travels back through a request/acknowledge bus synchronizer. The multi-bit index is therefore only sampled while it is held stable. Each slot's address is a fixed base plus the slot index times a frame stride. For a stream with several channels, one instance is used per channel.

Top module: `tfb_ctrl`

## Requirements
- R1: After reset the writer slot is 0, `wr_base` equals `BASE_ADDR` and `rd_valid` is 0.
- R2: A frame is complete when `wr_frame_end` arrives while a frame is open. A frame opens at `wr_frame_start`. One writer clock cycle after a complete frame, the slot just filled becomes the latest frame. The writer then moves to the lowest-numbered slot among 0, 1 and 2 that is neither the slot just filled nor the slot held by the reader. Before the reader holds any slot, only the slot just filled is excluded.
- R3: A `wr_frame_end` with no open frame has no effect. A further `wr_frame_start` inside an open frame does not change the writer slot.
- R4: A reader frame start that arrives before any frame has completed leaves `rd_valid` at 0.
- R5: When a reader frame start arrives after at least one completed frame, the reader is granted the latest completed slot. `rd_slot`, `rd_base` and `rd_valid` (set to 1) then appear in the reader domain within 40 writer clock cycles.
- R6: A reader frame start with no new completed frame since the previous one grants the same slot again.
- R7: Once the reader holds a slot, the writer slot is never equal to it.
- R8: Slot codes are 0, 1 and 2 only. A slot's base address is `BASE_ADDR + slot * FRAME_BYTES` on both sides.
- R9: The reader slot changes only as a result of a reader frame start. Completed writer frames alone leave it unchanged, and once `rd_valid` is 1 it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Writer (capture) clock |
| wr_rst | input | 1 | Synchronous active-high reset, writer domain |
| wr_frame_start | input | 1 | One-cycle strobe: writer begins a frame |
| wr_frame_end | input | 1 | One-cycle strobe: writer finished a frame |
| wr_slot | output | 2 | Slot the writer is filling |
| wr_base | output | ADDR_W | Base address of the writer slot |
| rd_clk | input | 1 | Reader (display/export) clock |
| rd_rst | input | 1 | Synchronous active-high reset, reader domain |
| rd_frame_start | input | 1 | One-cycle strobe: reader begins a frame |
| rd_slot | output | 2 | Slot the reader is draining |
| rd_base | output | ADDR_W | Base address of the reader slot |
| rd_valid | output | 1 | Reader holds a completed frame |

## Verification
Suppose the arbiter's record of the reader slot goes stale. Then the very next completed frame would steer the writer onto the slot being read, and `wr_slot` would equal `rd_slot` one writer cycle after the end strobe. A wrong latest-frame record does not show until the next reader frame start; it then appears on `rd_slot` tens of cycles later, after the round trip through the synchronizers. The bench therefore follows every writer end strobe with a check of `wr_slot`. It checks the reader outputs only after a wait long enough for both crossings to finish.

// File: rtl/tfb_pkg.sv
package tfb_pkg;

    localparam int NUM_SLOTS = 3;

    typedef logic [1:0] slot_t;

    // Slot granted to the reader, as seen in the writer domain.
    typedef struct packed {
        logic  has;
        slot_t slot;
    } rd_grant_t;

    localparam int GRANT_W = $bits(rd_grant_t);

    // Lowest slot that is neither a nor (when b_used) b.
    function automatic slot_t pick_free(slot_t a, slot_t b, logic b_used);
        slot_t r;
        logic  found;
        r     = '0;
        found = 1'b0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (!found && slot_t'(i) != a && (!b_used || slot_t'(i) != b)) begin
                r     = slot_t'(i);
                found = 1'b1;
            end
        end
        return r;
    endfunction

    function automatic logic [63:0] slot_addr(logic [63:0] base,
                                              logic [63:0] stride,
                                              slot_t s);
        return base + stride * {62'd0, s};
    endfunction

endpackage

// File: rtl/tfb_pulse_sync.sv
module tfb_pulse_sync #(
    parameter int STAGES = 2
) (
    input  logic src_clk,
    input  logic src_rst,
    input  logic src_pulse,
    input  logic dst_clk,
    input  logic dst_rst,
    output logic dst_pulse
);
    logic              tgl_q;
    logic [STAGES:0]   sh_q;

    always_ff @(posedge src_clk) begin
        if (src_rst) tgl_q <= 1'b0;
        else         tgl_q <= tgl_q ^ src_pulse;
    end

    always_ff @(posedge dst_clk) begin
        if (dst_rst) sh_q <= '0;
        else         sh_q <= {sh_q[STAGES-1:0], tgl_q};
    end

    assign dst_pulse = sh_q[STAGES] ^ sh_q[STAGES-1];

endmodule

// File: rtl/tfb_bus_sync.sv
module tfb_bus_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         src_clk,
    input  logic         src_rst,
    input  logic [W-1:0] src_data,
    input  logic         dst_clk,
    input  logic         dst_rst,
    output logic [W-1:0] dst_data
);
    logic [W-1:0]      hold_q;
    logic              req_q;
    logic [STAGES-1:0] ack_sh_q;
    logic              ack_q;
    logic [STAGES:0]   req_sh_q;
    logic              src_idle;
    logic              dst_edge;

    // Source side: hold a value stable until its request is acknowledged.
    assign src_idle = (req_q == ack_sh_q[STAGES-1]);

    always_ff @(posedge src_clk) begin
        if (src_rst) begin
            hold_q   <= '0;
            req_q    <= 1'b0;
            ack_sh_q <= '0;
        end else begin
            ack_sh_q <= {ack_sh_q[STAGES-2:0], ack_q};
            if (src_idle && src_data != hold_q) begin
                hold_q <= src_data;
                req_q  <= ~req_q;
            end
        end
    end

    // Destination side: capture on a request edge, return the toggle.
    assign dst_edge = req_sh_q[STAGES] ^ req_sh_q[STAGES-1];

    always_ff @(posedge dst_clk) begin
        if (dst_rst) begin
            req_sh_q <= '0;
            ack_q    <= 1'b0;
            dst_data <= '0;
        end else begin
            req_sh_q <= {req_sh_q[STAGES-1:0], req_q};
            if (dst_edge) begin
                dst_data <= hold_q;
                ack_q    <= req_sh_q[STAGES-1];
            end
        end
    end

endmodule

// File: rtl/tfb_slot_arbiter.sv
module tfb_slot_arbiter
    import tfb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      frame_start,
    input  logic      frame_end,
    input  logic      rd_req,
    output slot_t     wr_slot,
    output rd_grant_t rd_grant,
    output logic      frame_open
);
    slot_t     latest_q;
    logic      have_q;
    logic      commit;
    slot_t     latest_n;
    logic      have_n;
    rd_grant_t grant_n;
    slot_t     wr_n;

    assign commit = frame_end && frame_open;

    always_comb begin
        latest_n = commit ? wr_slot : latest_q;
        have_n   = have_q || commit;
        grant_n  = rd_grant;
        if (rd_req && have_n) begin
            grant_n.has  = 1'b1;
            grant_n.slot = latest_n;
        end
        wr_n = commit ? pick_free(wr_slot, grant_n.slot, grant_n.has) : wr_slot;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_slot    <= '0;
            latest_q   <= '0;
            have_q     <= 1'b0;
            rd_grant   <= '0;
            frame_open <= 1'b0;
        end else begin
            wr_slot    <= wr_n;
            latest_q   <= latest_n;
            have_q     <= have_n;
            rd_grant   <= grant_n;
            if (frame_start)    frame_open <= 1'b1;
            else if (frame_end) frame_open <= 1'b0;
        end
    end

endmodule

// File: rtl/tfb_ctrl.sv
module tfb_ctrl
    import tfb_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 'h1000_0000,
    parameter int unsigned       FRAME_BYTES = 1280 * 720 * 3,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              wr_frame_start,
    input  logic              wr_frame_end,
    output logic [1:0]        wr_slot,
    output logic [ADDR_W-1:0] wr_base,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              rd_frame_start,
    output logic [1:0]        rd_slot,
    output logic [ADDR_W-1:0] rd_base,
    output logic              rd_valid
);
    localparam logic [63:0] BASE64   = 64'(BASE_ADDR);
    localparam logic [63:0] STRIDE64 = 64'(FRAME_BYTES);

    logic      rd_req_w;
    slot_t     wr_slot_w;
    rd_grant_t grant_w;
    rd_grant_t grant_r;
    logic      frame_open;

    tfb_pulse_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .src_clk   (rd_clk),
        .src_rst   (rd_rst),
        .src_pulse (rd_frame_start),
        .dst_clk   (wr_clk),
        .dst_rst   (wr_rst),
        .dst_pulse (rd_req_w)
    );

    tfb_slot_arbiter u_arb (
        .clk         (wr_clk),
        .rst         (wr_rst),
        .frame_start (wr_frame_start),
        .frame_end   (wr_frame_end),
        .rd_req      (rd_req_w),
        .wr_slot     (wr_slot_w),
        .rd_grant    (grant_w),
        .frame_open  (frame_open)
    );

    tfb_bus_sync #(.W(GRANT_W), .STAGES(SYNC_STAGES)) u_grant_sync (
        .src_clk  (wr_clk),
        .src_rst  (wr_rst),
        .src_data (grant_w),
        .dst_clk  (rd_clk),
        .dst_rst  (rd_rst),
        .dst_data (grant_r)
    );

    assign wr_slot  = wr_slot_w;
    assign wr_base  = ADDR_W'(slot_addr(BASE64, STRIDE64, wr_slot_w));
    assign rd_slot  = grant_r.slot;
    assign rd_valid = grant_r.has;
    assign rd_base  = ADDR_W'(slot_addr(BASE64, STRIDE64, grant_r.slot));

endmodule

// File: rtl/tfb_ctrl_chk.sv
module tfb_ctrl_chk (
    input logic       wr_clk,
    input logic       wr_rst,
    input logic       wr_frame_end,
    input logic       frame_open,
    input logic [1:0] wr_slot,
    input logic [2:0] grant_w,
    input logic       rd_clk,
    input logic       rd_rst,
    input logic [1:0] rd_slot,
    input logic       rd_valid
);
    // R2: a completed frame moves the writer to another slot
    a_r2_moves: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (wr_frame_end && frame_open) |=> (wr_slot != $past(wr_slot)));

    // R3: an end strobe without an open frame is ignored
    a_r3_ignored: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (wr_frame_end && !frame_open) |=> $stable(wr_slot));

    // R7: writer never sits on the granted reader slot
    a_r7_no_collision: assert property (@(posedge wr_clk) disable iff (wr_rst)
        grant_w[2] |-> (wr_slot != grant_w[1:0]));

    // R8: only three slot codes exist
    a_r8_wr_range: assert property (@(posedge wr_clk) disable iff (wr_rst)
        wr_slot != 2'd3);
    a_r8_rd_range: assert property (@(posedge rd_clk) disable iff (rd_rst)
        rd_slot != 2'd3);

    // R9: reader validity never drops, and a reader slot exists only when valid
    a_r9_valid_holds: assert property (@(posedge rd_clk) disable iff (rd_rst)
        rd_valid |=> rd_valid);
    a_r9_slot_needs_valid: assert property (@(posedge rd_clk) disable iff (rd_rst)
        !$stable(rd_slot) |-> rd_valid);
endmodule

bind tfb_ctrl tfb_ctrl_chk u_chk (
    .wr_clk       (wr_clk),
    .wr_rst       (wr_rst),
    .wr_frame_end (wr_frame_end),
    .frame_open   (frame_open),
    .wr_slot      (wr_slot),
    .grant_w      (grant_w),
    .rd_clk       (rd_clk),
    .rd_rst       (rd_rst),
    .rd_slot      (rd_slot),
    .rd_valid     (rd_valid)
);

// File: tb/tfb_ctrl_bench.sv
`timescale 1ns/1ps
module tfb_ctrl_bench;
    localparam int          AW     = 32;
    localparam logic [31:0] BASE   = 32'h1000_0000;
    localparam int unsigned STRIDE = 1280 * 720 * 3;

    logic wr_clk = 1'b0, rd_clk = 1'b0;
    logic wr_rst = 1'b1, rd_rst = 1'b1;
    logic wr_frame_start = 1'b0, wr_frame_end = 1'b0, rd_frame_start = 1'b0;
    logic [1:0]    wr_slot, rd_slot;
    logic [AW-1:0] wr_base, rd_base;
    logic          rd_valid;

    always #4    wr_clk = ~wr_clk;   // 125 MHz
    always #5.5  rd_clk = ~rd_clk;   // unrelated reader clock

    tfb_ctrl #(.ADDR_W(AW), .BASE_ADDR(BASE), .FRAME_BYTES(STRIDE)) u_tfb_ctrl (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_frame_start(wr_frame_start),
        .wr_frame_end(wr_frame_end), .wr_slot(wr_slot), .wr_base(wr_base),
        .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_frame_start(rd_frame_start),
        .rd_slot(rd_slot), .rd_base(rd_base), .rd_valid(rd_valid));

    typedef struct {
        string       req;
        int          sel;   // 0 wr_slot, 1 wr_base, 2 rd_slot, 3 rd_base, 4 rd_valid, 5 wr!=rd
        longint      exp;
    } item_t;

    item_t q[$];
    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // Reference model, written from the requirements
    int m_wr = 0, m_latest = 0, m_rd = 0;
    bit m_have = 0, m_rd_has = 0, m_open = 0;

    function automatic int free_slot(int a, int b, bit b_used);
        for (int i = 0; i < 3; i++)
            if (i != a && (!b_used || i != b)) return i;
        return 0;
    endfunction

    function automatic longint addr_of(int s);
        return longint'(BASE) + longint'(s) * longint'(STRIDE);
    endfunction

    task automatic push(string r, int sel, longint e);
        item_t it;
        it.req = r; it.sel = sel; it.exp = e;
        q.push_back(it);
    endtask

    task automatic settle();
        wait (q.size() == 0);
    endtask

    // Monitor: compares queued expectations with the ports
    initial begin
        forever begin
            longint act;
            item_t it;
            wait (q.size() > 0);
            it = q.pop_front();
            case (it.sel)
                0: act = wr_slot;
                1: act = wr_base;
                2: act = rd_slot;
                3: act = rd_base;
                4: act = rd_valid;
                default: act = (rd_valid && wr_slot == rd_slot) ? 0 : 1;
            endcase
            n_cmp++;
            if (act != it.exp) begin
                n_bad++;
                $display("FAIL %s sel=%0d actual=%0d expected=%0d", it.req, it.sel, act, it.exp);
            end
        end
    end

    task automatic wr_pulse(bit st, bit en);
        @(negedge wr_clk);
        wr_frame_start = st; wr_frame_end = en;
        @(negedge wr_clk);
        wr_frame_start = 0; wr_frame_end = 0;
        if (st) m_open = 1;
        else if (en) begin
            if (m_open) begin
                m_latest = m_wr; m_have = 1;
                m_wr = free_slot(m_wr, m_rd, m_rd_has);
            end
            m_open = 0;
        end
    endtask

    task automatic write_frame(string r);
        wr_pulse(1, 0);
        repeat (5) @(negedge wr_clk);
        wr_pulse(0, 1);
        push(r, 0, m_wr);
        push("R8", 1, addr_of(m_wr));
        push("R7", 5, 1);
        settle();
    endtask

    task automatic rd_start();
        @(negedge rd_clk);
        rd_frame_start = 1;
        @(negedge rd_clk);
        rd_frame_start = 0;
        if (m_have) begin m_rd = m_latest; m_rd_has = 1; end
        repeat (40) @(negedge wr_clk);
    endtask

    task automatic check_reader(string r);
        push(r, 4, m_rd_has);
        if (m_rd_has) begin
            push(r, 2, m_rd);
            push("R8", 3, addr_of(m_rd));
        end
        settle();
    endtask

    initial begin
        fork
            begin
                repeat (20000) @(posedge wr_clk);
                if (!done) begin
                    n_bad++;
                    $display("FAIL watchdog actual=hung expected=finished");
                    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                    $finish;
                end
            end
        join_none

        repeat (4) @(negedge rd_clk);
        repeat (2) @(negedge wr_clk);
        wr_rst = 0; rd_rst = 0;
        repeat (6) @(negedge wr_clk);

        // R1: reset state
        push("R1", 0, 0); push("R1", 1, BASE); push("R1", 4, 0);
        settle();

        // R4: reader start before any completed frame
        rd_start();
        check_reader("R4");

        // R3: end strobe with no open frame
        wr_pulse(0, 1);
        push("R3", 0, 0);
        settle();

        // R2: first frame, reader holds nothing yet
        write_frame("R2");

        // R5: reader takes latest completed slot (0)
        rd_start();
        check_reader("R5");

        // R2/R7: writes rotate around the reader slot
        write_frame("R2");
        write_frame("R2");

        // R3: a second start inside an open frame does not move the writer
        wr_pulse(1, 0);
        wr_pulse(1, 0);
        push("R3", 0, m_wr);
        settle();
        wr_pulse(0, 1);
        push("R3", 0, m_wr);
        push("R7", 5, 1);
        settle();

        // R5 then R6: repeated reader starts without new frames
        rd_start();
        check_reader("R5");
        rd_start();
        check_reader("R6");

        // R9: writer completions alone leave reader slot unchanged
        write_frame("R2");
        write_frame("R2");
        repeat (40) @(negedge wr_clk);
        check_reader("R9");

        // R5: reader now picks newest frame
        rd_start();
        check_reader("R5");
        write_frame("R7");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule